// File: doc/BRIEF.md
# Dual Wiper Register Command Controller

This block interprets command frames for a pair of 8-bit wiper codes. A byte-level serial receiver in front of it marks the start and the end of each chip-select window and hands over the bytes received in between. Every frame opens with an identifier byte that has to match a fixed type code and the two address pins. If it does not match, the rest of the frame is discarded. The next byte carries an opcode, a data-register index and a wiper index. Depending on the opcode, the block reads or writes a wiper register, reads or writes one of the four data registers that belong to each wiper, copies between the two kinds of register for one wiper or for both, or reports a status bit.

A stepping mode nudges the chosen wiper by one code per serial clock. The direction follows the data-line level sampled on that clock. At reset each wiper takes the value of data register 0 of its own wiper. Changes to data registers are held back until chip select is released, and at that moment a commit request goes to an external write-cycle controller. A frame that ends early therefore changes nothing.

Received bytes arrive on a valid/ready stream. `rx_ready` is low during the boot cycle after reset and while a reply byte waits on the transmit stream. In every other state it is high, and bytes that the current frame does not need are accepted and dropped. The reply stream holds `tx_valid` and `tx_data` steady until `tx_ready` is seen. Data comes in least-significant byte per transfer: one byte per handshake.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: In the first clock after reset release, wiper n is loaded with the reset value of data register 0 of wiper n. During that boot cycle `rx_ready` is low. A fresh reset gives wiper 0 = 0x80 and wiper 1 = 0xC0, and data register d of wiper n = 0x80 + 0x40*n + d.
- R2: The first byte of a frame is accepted only if bits 7:4 are 0101, bits 3:2 are 00 and bits 1:0 equal `dev_addr`. For any other value, every following byte of the frame has no effect.
- R3: In the second byte, bits 7:4 are the opcode, bits 3:2 the data-register index and bits 1:0 the wiper index. A wiper index of 2 or 3 makes the whole command do nothing.
- R4: Opcode 1010 followed by a data byte writes that byte into the selected wiper, and the new value shows on `wiper_codes` on the clock after the data byte is accepted. Wiper n is `wiper_codes[8n+7:8n]`.
- R5: Opcode 1001 replies with the selected wiper, opcode 1011 with the selected data register, and opcode 0101 with `{7'b0, wip}`. The reply is held on `tx_data` with `tx_valid` high until `tx_ready` is seen.
- R6: Opcode 1100 with a data byte, and opcode 1110 (selected wiper into the selected data register), change the data register only in the cycle where `frame_end` is high. `commit_req` is high in that same cycle. If the frame ends before all its bytes have arrived, nothing changes and `commit_req` stays low.
- R7: Opcode 1101 copies the selected data register into its wiper on the clock after the instruction byte.
- R8: Opcode 0001 loads both wipers from their data register at the given index. Opcode 1000 stores both wipers into that index at `frame_end`.
- R9: After opcode 0010, each `step_valid` pulse moves the selected wiper by +1 when `step_dir` is 1 and by -1 when it is 0. This lasts until `frame_end`; after that, step pulses have no effect.
- R10: A step never wraps. Stepping up at 255 leaves 255, and stepping down at 0 leaves 0.
- R11: Opcodes 0000, 0011, 0100, 0110, 0111 and 1111 change nothing and produce no reply. The bytes that follow are ignored until the next `frame_start`.
- R12: `rx_ready` is low while `tx_valid` is high. Bytes beyond those a command needs are accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 2 | Address pins compared with identifier bits 1:0 |
| frame_start | input | 1 | One-cycle pulse: chip select asserted |
| frame_end | input | 1 | One-cycle pulse: chip select released |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Block can take a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte valid |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| tx_data | output | 8 | Reply byte |
| step_valid | input | 1 | One serial-clock pulse in stepping mode |
| step_dir | input | 1 | Data-line sample with the pulse: 1 up, 0 down |
| wip | input | 1 | Write-in-progress flag from the write-cycle controller |
| commit_req | output | 1 | Pending data-register update applied this cycle |
| wiper_codes | output | 16 | Both wiper codes, wiper 0 in the low byte |

## Verification
The case hardest to reach from the ports is a wiper sitting at either end of its range while step pulses keep arriving. To get there, the bench writes a code near the top, steps past 255, and then steps down more than 256 times through the whole range, checking every step against a saturating count. The identifier filter is swept over all 256 first-byte values for each of the four address-pin settings. Data-register changes are only visible through read commands, so every write, copy and aborted frame is followed by a read-back.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int DWC_CODE_W  = 8;
  localparam int DWC_WIPERS  = 2;
  localparam int DWC_DREGS   = 4;
  localparam logic [3:0] DWC_DEV_TYPE = 4'b0101;

  typedef enum logic [3:0] {
    OP_GDR2W  = 4'b0001,
    OP_STEP   = 4'b0010,
    OP_STATUS = 4'b0101,
    OP_GW2DR  = 4'b1000,
    OP_RD_W   = 4'b1001,
    OP_WR_W   = 4'b1010,
    OP_RD_DR  = 4'b1011,
    OP_WR_DR  = 4'b1100,
    OP_DR2W   = 4'b1101,
    OP_W2DR   = 4'b1110
  } dwc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_INSTR, ST_DATA, ST_REPLY, ST_STEP, ST_DONE
  } dwc_state_e;
endpackage

// File: rtl/dwc_wiper_bank.sv
module dwc_wiper_bank #(
  parameter int W  = 8,
  parameter int NW = 2,
  localparam int PW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  dr0 [NW],
  input  logic [NW-1:0] wl_en,
  input  logic [W-1:0]  wl_val [NW],
  input  logic          st_en,
  input  logic [PW-1:0] st_sel,
  input  logic          st_up,
  output logic          boot,
  output logic [W-1:0]  wiper_q [NW]
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot <= 1'b1;
    else        boot <= 1'b0;
  end

  for (genvar w = 0; w < NW; w++) begin : g_wiper
    logic hit;
    assign hit = st_en && (st_sel == PW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiper_q[w] <= '0;
      end else if (boot) begin
        wiper_q[w] <= dr0[w];
      end else if (wl_en[w]) begin
        wiper_q[w] <= wl_val[w];
      end else if (hit) begin
        if (st_up && wiper_q[w] != TOP)       wiper_q[w] <= wiper_q[w] + ONE;
        else if (!st_up && wiper_q[w] != '0)  wiper_q[w] <= wiper_q[w] - ONE;
      end
    end

    // R1
    boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot |=> wiper_q[w] == $past(dr0[w]));
    // R10
    top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && st_up && !boot && !wl_en[w] && wiper_q[w] == TOP) |=> wiper_q[w] == TOP);
    // R10
    bottom_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !st_up && !boot && !wl_en[w] && wiper_q[w] == '0) |=> wiper_q[w] == '0);
    // R9
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && st_up && !boot && !wl_en[w] && wiper_q[w] != TOP) |=>
        wiper_q[w] == $past(wiper_q[w]) + ONE);
  end
endmodule

// File: rtl/dwc_data_bank.sv
module dwc_data_bank #(
  parameter int W  = 8,
  parameter int NW = 2,
  parameter int ND = 4,
  parameter logic [NW*ND*W-1:0] INIT = '0,
  localparam int RW = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [NW-1:0] we,
  input  logic [RW-1:0] idx,
  input  logic [W-1:0]  val [NW],
  output logic [W-1:0]  dr_q [NW][ND]
);
  for (genvar w = 0; w < NW; w++) begin : g_w
    for (genvar d = 0; d < ND; d++) begin : g_d
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          dr_q[w][d] <= INIT[(w*ND+d)*W +: W];
        else if (commit && we[w] && idx == RW'(d))
          dr_q[w][d] <= val[w];
      end

      // R6
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(dr_q[w][d]));
    end
  end
endmodule

// File: rtl/dwc_frame_seq.sv
module dwc_frame_seq
  import dwc_pkg::*;
#(
  parameter int W  = 8,
  parameter int NW = 2,
  parameter int ND = 4,
  localparam int PW = (NW > 1) ? $clog2(NW) : 1,
  localparam int RW = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot,
  input  logic [1:0]    dev_addr,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          step_valid,
  input  logic          step_dir,
  input  logic          wip,
  input  logic [W-1:0]  wiper_q [NW],
  input  logic [W-1:0]  dr_q [NW][ND],
  output logic [NW-1:0] wl_en,
  output logic [W-1:0]  wl_val [NW],
  output logic          st_en,
  output logic [PW-1:0] st_sel,
  output logic          st_up,
  output logic          commit,
  output logic [NW-1:0] pend_we,
  output logic [RW-1:0] pend_idx,
  output logic [W-1:0]  pend_val [NW]
);
  dwc_state_e state, nxt;
  dwc_op_e    op_q, op_in;
  logic [PW-1:0] wsel_q, wsel_in;
  logic [RW-1:0] rsel_q, rsel_in, pset_idx;
  logic          rx_fire, id_ok, p_ok, tx_load;
  logic [7:0]    tx_nxt, tx_q;
  logic [NW-1:0] pset_we;
  logic [W-1:0]  pset_val [NW];

  assign rx_ready = !boot && (state != ST_REPLY);
  assign tx_valid = (state == ST_REPLY);
  assign tx_data  = tx_q;
  assign rx_fire  = rx_valid && rx_ready;
  assign id_ok    = (rx_data[7:4] == DWC_DEV_TYPE) && (rx_data[3:2] == 2'b00) &&
                    (rx_data[1:0] == dev_addr);
  assign op_in    = dwc_op_e'(rx_data[7:4]);
  assign rsel_in  = rx_data[RW+1:2];
  assign wsel_in  = rx_data[PW-1:0];
  assign p_ok     = (32'(rx_data[1:0]) < NW);
  assign commit   = frame_end && (|pend_we);
  assign st_sel   = wsel_q;
  assign st_up    = step_dir;

  always_comb begin
    nxt      = state;
    wl_en    = '0;
    pset_we  = '0;
    pset_idx = rsel_q;
    st_en    = 1'b0;
    tx_load  = 1'b0;
    tx_nxt   = '0;
    for (int w = 0; w < NW; w++) begin
      wl_val[w]   = '0;
      pset_val[w] = '0;
    end
    if (frame_start) begin
      nxt = ST_ID;
    end else if (frame_end) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_ID: if (rx_fire) nxt = id_ok ? ST_INSTR : ST_DONE;
        ST_INSTR: if (rx_fire) begin
          nxt = ST_DONE;
          pset_idx = rsel_in;
          if (p_ok) begin
            case (op_in)
              OP_RD_W: begin
                tx_load = 1'b1; tx_nxt = 8'(wiper_q[wsel_in]); nxt = ST_REPLY;
              end
              OP_RD_DR: begin
                tx_load = 1'b1; tx_nxt = 8'(dr_q[wsel_in][rsel_in]); nxt = ST_REPLY;
              end
              OP_STATUS: begin
                tx_load = 1'b1; tx_nxt = {7'b0, wip}; nxt = ST_REPLY;
              end
              OP_WR_W, OP_WR_DR: nxt = ST_DATA;
              OP_DR2W: begin
                wl_en[wsel_in]  = 1'b1;
                wl_val[wsel_in] = dr_q[wsel_in][rsel_in];
              end
              OP_W2DR: begin
                pset_we[wsel_in]  = 1'b1;
                pset_val[wsel_in] = wiper_q[wsel_in];
              end
              OP_GDR2W: for (int w = 0; w < NW; w++) begin
                wl_en[w]  = 1'b1;
                wl_val[w] = dr_q[w][rsel_in];
              end
              OP_GW2DR: for (int w = 0; w < NW; w++) begin
                pset_we[w]  = 1'b1;
                pset_val[w] = wiper_q[w];
              end
              OP_STEP: nxt = ST_STEP;
              default: nxt = ST_DONE;
            endcase
          end
        end
        ST_DATA: if (rx_fire) begin
          nxt = ST_DONE;
          if (op_q == OP_WR_W) begin
            wl_en[wsel_q]  = 1'b1;
            wl_val[wsel_q] = rx_data[W-1:0];
          end else begin
            pset_we[wsel_q]  = 1'b1;
            pset_val[wsel_q] = rx_data[W-1:0];
          end
        end
        ST_REPLY: if (tx_ready) nxt = ST_DONE;
        ST_STEP:  st_en = step_valid;
        default:  nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= OP_STATUS;
      wsel_q   <= '0;
      rsel_q   <= '0;
      tx_q     <= '0;
      pend_we  <= '0;
      pend_idx <= '0;
      for (int w = 0; w < NW; w++) pend_val[w] <= '0;
    end else begin
      state <= nxt;
      if (state == ST_INSTR && rx_fire && !frame_start && !frame_end) begin
        op_q   <= op_in;
        wsel_q <= wsel_in;
        rsel_q <= rsel_in;
      end
      if (tx_load) tx_q <= tx_nxt;
      if (frame_start || frame_end) begin
        pend_we <= '0;
      end else if (|pset_we) begin
        pend_idx <= pset_idx;
        for (int w = 0; w < NW; w++) begin
          if (pset_we[w]) begin
            pend_we[w]  <= 1'b1;
            pend_val[w] <= pset_val[w];
          end
        end
      end
    end
  end

  // R12
  reply_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);
  // R5
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !frame_start && !frame_end) |=> tx_valid && $stable(tx_data));
  // R6
  commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> frame_end);
  // R9
  step_only_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> (state == ST_STEP));
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
  import dwc_pkg::*;
#(
  parameter int CODE_W = DWC_CODE_W,
  parameter int NWIP   = DWC_WIPERS,
  parameter int NDR    = DWC_DREGS,
  parameter logic [NWIP*NDR*CODE_W-1:0] DR_INIT = {
    8'hC3, 8'hC2, 8'hC1, 8'hC0, 8'h83, 8'h82, 8'h81, 8'h80}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             dev_addr,
  input  logic                   frame_start,
  input  logic                   frame_end,
  input  logic                   rx_valid,
  output logic                   rx_ready,
  input  logic [7:0]             rx_data,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  input  logic                   step_valid,
  input  logic                   step_dir,
  input  logic                   wip,
  output logic                   commit_req,
  output logic [NWIP*CODE_W-1:0] wiper_codes
);
  localparam int PW = (NWIP > 1) ? $clog2(NWIP) : 1;
  localparam int RW = (NDR > 1) ? $clog2(NDR) : 1;

  logic              boot, st_en, st_up;
  logic [PW-1:0]     st_sel;
  logic [NWIP-1:0]   wl_en, pend_we;
  logic [RW-1:0]     pend_idx;
  logic [CODE_W-1:0] wl_val [NWIP];
  logic [CODE_W-1:0] pend_val [NWIP];
  logic [CODE_W-1:0] wiper_q [NWIP];
  logic [CODE_W-1:0] dr0 [NWIP];
  logic [CODE_W-1:0] dr_q [NWIP][NDR];

  for (genvar w = 0; w < NWIP; w++) begin : g_out
    assign wiper_codes[w*CODE_W +: CODE_W] = wiper_q[w];
    assign dr0[w] = dr_q[w][0];
  end

  dwc_frame_seq #(.W(CODE_W), .NW(NWIP), .ND(NDR)) seq_i (
    .clk(clk), .rst_n(rst_n), .boot(boot), .dev_addr(dev_addr),
    .frame_start(frame_start), .frame_end(frame_end),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .step_valid(step_valid), .step_dir(step_dir), .wip(wip),
    .wiper_q(wiper_q), .dr_q(dr_q),
    .wl_en(wl_en), .wl_val(wl_val), .st_en(st_en), .st_sel(st_sel), .st_up(st_up),
    .commit(commit_req), .pend_we(pend_we), .pend_idx(pend_idx), .pend_val(pend_val)
  );

  dwc_wiper_bank #(.W(CODE_W), .NW(NWIP)) wipers_i (
    .clk(clk), .rst_n(rst_n), .dr0(dr0), .wl_en(wl_en), .wl_val(wl_val),
    .st_en(st_en), .st_sel(st_sel), .st_up(st_up), .boot(boot), .wiper_q(wiper_q)
  );

  dwc_data_bank #(.W(CODE_W), .NW(NWIP), .ND(NDR), .INIT(DR_INIT)) dregs_i (
    .clk(clk), .rst_n(rst_n), .commit(commit_req), .we(pend_we), .idx(pend_idx),
    .val(pend_val), .dr_q(dr_q)
  );
endmodule

// File: tb/dual_wiper_ctrl_tb.sv
module dual_wiper_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] dev_addr = 2'd0;
  logic frame_start = 1'b0, frame_end = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = '0;
  logic step_valid = 1'b0, step_dir = 1'b0, wip = 1'b0;
  logic rx_ready, tx_valid, commit_req;
  logic [7:0] tx_data;
  logic [15:0] wiper_codes;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] wm [2];
  logic [7:0] dm [2][4];
  logic last_commit;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wiper_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
    .frame_start(frame_start), .frame_end(frame_end),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .step_valid(step_valid), .step_dir(step_dir), .wip(wip),
    .commit_req(commit_req), .wiper_codes(wiper_codes)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual no completion expected completion within %0d cycles", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_ok();
    return {4'b0101, 2'b00, dev_addr};
  endfunction

  task automatic fstart();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic fend();
    @(negedge clk); frame_end = 1'b1;
    #1 last_commit = commit_req;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic step(input logic d);
    @(negedge clk); step_valid = 1'b1; step_dir = d;
    @(negedge clk); step_valid = 1'b0;
  endtask

  task automatic reply(output logic [7:0] v);
    while (!tx_valid) @(negedge clk);
    chk("R12 rx_ready low during reply", {7'b0, rx_ready}, 8'h00);
    v = tx_data;
    tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic rd(input logic [7:0] instr, output logic [7:0] v);
    fstart(); send(id_ok()); send(instr); reply(v); fend();
  endtask

  task automatic chk_wipers(input string req);
    chk(req, wiper_codes[7:0], wm[0]);
    chk(req, wiper_codes[15:8], wm[1]);
  endtask

  task automatic wr_wiper(input int p, input logic [7:0] v);
    fstart(); send(id_ok()); send(8'hA0 | 8'(p)); send(v);
    wm[p] = v;
    chk("R4 wiper after data byte", wiper_codes[p*8 +: 8], v);
    fend();
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] opbad [6];
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 4; d++) dm[w][d] = 8'h80 + 8'(w * 64) + 8'(d);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 rx_ready low in boot", {7'b0, rx_ready}, 8'h00);
    @(negedge clk);
    wm[0] = dm[0][0]; wm[1] = dm[1][0];
    chk_wipers("R1 wipers from data register 0");
    chk("R1 rx_ready after boot", {7'b0, rx_ready}, 8'h01);
    chk("R5 no reply at reset", {7'b0, tx_valid}, 8'h00);
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 4; d++) begin
        rd(8'hB0 | 8'(d << 2) | 8'(w), v);
        chk("R1 R5 data register reset value", v, dm[w][d]);
      end

    wr_wiper(0, 8'h12);
    wr_wiper(1, 8'hED);
    chk_wipers("R4 both wipers");

    // R2 identifier sweep over every first byte and every address setting
    for (int a = 0; a < 4; a++) begin
      dev_addr = 2'(a);
      for (int id = 0; id < 256; id++) begin
        logic [7:0] dv;
        dv = 8'(id) ^ 8'h3C ^ 8'(a);
        fstart(); send(8'(id)); send(8'hA0); send(dv); fend();
        if (id[7:4] == 4'b0101 && id[3:2] == 2'b00 && id[1:0] == 2'(a)) wm[0] = dv;
        chk("R2 identifier filter", wiper_codes[7:0], wm[0]);
      end
    end
    dev_addr = 2'd2;

    // R5 reads
    rd(8'h90, v); chk("R5 read wiper 0", v, wm[0]);
    rd(8'h91, v); chk("R5 read wiper 1", v, wm[1]);
    wip = 1'b0; rd(8'h51, v); chk("R5 status idle", v, 8'h00);
    wip = 1'b1; rd(8'h51, v); chk("R5 status busy", v, 8'h01);
    wip = 1'b0;

    // R6 data register writes, committed at frame end
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 4; d++) begin
        logic [7:0] dv;
        dv = 8'h11 * 8'(d + 1) ^ (w == 1 ? 8'hF0 : 8'h00);
        fstart(); send(id_ok()); send(8'hC0 | 8'(d << 2) | 8'(w)); send(dv); fend();
        dm[w][d] = dv;
        chk("R6 commit_req at frame end", {7'b0, last_commit}, 8'h01);
        rd(8'hB0 | 8'(d << 2) | 8'(w), v);
        chk("R6 data register written", v, dm[w][d]);
      end
    // R6 frame cut short after the instruction byte
    fstart(); send(id_ok()); send(8'hC0 | 8'(2 << 2) | 8'd1); fend();
    chk("R6 no commit on short frame", {7'b0, last_commit}, 8'h00);
    rd(8'hB0 | 8'(2 << 2) | 8'd1, v);
    chk("R6 short frame leaves register", v, dm[1][2]);
    // R6 wiper to data register copy
    wr_wiper(0, 8'h5A);
    fstart(); send(id_ok()); send(8'hE0 | 8'(3 << 2));
    rd(8'hB0 | 8'(3 << 2), v);
    chk("R6 copy held until frame end", v, dm[0][3]);
    fstart(); send(id_ok()); send(8'hE0 | 8'(3 << 2)); fend();
    dm[0][3] = wm[0];
    chk("R6 copy commit", {7'b0, last_commit}, 8'h01);
    rd(8'hB0 | 8'(3 << 2), v);
    chk("R6 wiper copied to data register", v, dm[0][3]);

    // R7 single data register to wiper
    fstart(); send(id_ok()); send(8'hD0 | 8'(1 << 2) | 8'd1);
    wm[1] = dm[1][1];
    chk_wipers("R7 data register copied to wiper");
    fend();

    // R8 global copies
    fstart(); send(id_ok()); send(8'h10 | 8'(2 << 2));
    wm[0] = dm[0][2]; wm[1] = dm[1][2];
    chk_wipers("R8 global load of both wipers");
    fend();
    wr_wiper(0, 8'h0F); wr_wiper(1, 8'hF0);
    fstart(); send(id_ok()); send(8'h80); fend();
    dm[0][0] = wm[0]; dm[1][0] = wm[1];
    rd(8'hB0, v); chk("R8 global store wiper 0", v, dm[0][0]);
    rd(8'hB1, v); chk("R8 global store wiper 1", v, dm[1][0]);

    // R9 R10 stepping with saturation at both ends
    wr_wiper(1, 8'hFA);
    fstart(); send(id_ok()); send(8'h21);
    for (int i = 0; i < 10; i++) begin
      step(1'b1);
      if (wm[1] != 8'hFF) wm[1] = wm[1] + 8'd1;
      chk("R9 R10 step up", wiper_codes[15:8], wm[1]);
    end
    for (int i = 0; i < 260; i++) begin
      step(1'b0);
      if (wm[1] != 8'h00) wm[1] = wm[1] - 8'd1;
      chk("R9 R10 step down", wiper_codes[15:8], wm[1]);
    end
    for (int i = 0; i < 6; i++) begin
      step(1'(i % 2 == 0 || i == 5));
      if (i % 2 == 0 || i == 5) wm[1] = wm[1] + 8'd1;
      else if (wm[1] != 8'h00) wm[1] = wm[1] - 8'd1;
      chk("R9 mixed steps", wiper_codes[15:8], wm[1]);
    end
    fend();
    chk("R9 other wiper untouched", wiper_codes[7:0], wm[0]);
    step(1'b1);
    chk_wipers("R9 step after frame end ignored");

    // R11 opcodes outside the table
    opbad = '{8'h00, 8'h30, 8'h40, 8'h60, 8'h70, 8'hF0};
    for (int k = 0; k < 6; k++) begin
      fstart(); send(id_ok()); send(opbad[k]); send(8'hA0); send(8'h66); fend();
      chk("R11 no reply for unknown opcode", {7'b0, tx_valid}, 8'h00);
      chk("R11 no commit for unknown opcode", {7'b0, last_commit}, 8'h00);
      chk_wipers("R11 unknown opcode ignored");
    end

    // R3 wiper index out of range
    for (int p = 2; p < 4; p++) begin
      fstart(); send(id_ok()); send(8'hA0 | 8'(p)); send(8'h44); fend();
      chk_wipers("R3 wiper index 2 or 3 ignored");
    end
    fstart(); send(id_ok()); send(8'hC0 | 8'd3); send(8'h99); fend();
    chk("R3 no commit for bad index", {7'b0, last_commit}, 8'h00);

    // R12 surplus bytes after a complete command
    fstart(); send(id_ok()); send(8'hA0); send(8'h3E); send(8'h99); send(8'hA1);
    wm[0] = 8'h3E;
    chk_wipers("R12 surplus bytes ignored");
    fend();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule